// File: doc/BRIEF.md
# MCU Parallel Write Strobe Generator

This block drives the write side of an 8080-style parallel panel bus. Every accepted pixel word opens one bus cycle, whose length comes from a 5-bit period setting. Inside that cycle an active-low chip-select window and an active-low write window are placed by start and end positions. The start and end positions are either taken directly from configuration inputs or, in automatic mode, derived from the period alone. The word stays on the data bus for the whole bus cycle.

Words arrive through a valid/ready handshake. The block takes the next word on the last clock of the current cycle, so a steady stream runs back to back with no idle clock between cycles. Every configuration value is captured when a word is accepted, so changes made while a cycle is running do not affect that cycle. A frame hold can stop the stream at a frame boundary. When both hold controls are set, a word marked as the first of a frame is refused until the hold is released.

Top module: `mcu_strobe_gen`

## Requirements
- R1: A bus cycle lasts max(cfg_period, 3) + 1 clocks. The internal count runs 0 up to that clamped period. pix_ready is high on the last clock of a running cycle and low on every other clock of it.
- R2: With cfg_auto = 1 and clamped period P, the write window starts at (P+1)/4 - 1 and ends at 3*(P+1)/4 - 1, both using integer division.
- R3: With cfg_auto = 1, the select window starts at write start minus 3 when write start is above 2, and at 0 otherwise. It ends at write end minus 1 when write end is above 15, and at write end otherwise.
- R4: With cfg_auto = 0, the four position inputs set the windows directly. bus_cs_n and bus_wr_n are low exactly while the count c satisfies start <= c < end.
- R5: bus_data equals the accepted word and stays constant for every clock of that word's bus cycle.
- R6: Period, mode and positions are captured when a word is accepted. Changes during a running cycle do not affect it; they apply from the next accepted word.
- R7: A word offered with pix_valid high is accepted on the last clock of the running cycle, and its cycle starts on the next clock at count 0 with no idle clock.
- R8: When hold_sel and hold_frame are both 1, pix_ready is 0 while pix_sof is 1, so no frame-start word is accepted. Words without pix_sof are not held. With only one of the two bits set, nothing is held.
- R9: After reset, and whenever no cycle is running, bus_cs_n and bus_wr_n are 1 and pix_ready is 1 unless a hold applies (R8). bus_data is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_period | input | PER_W | Bus cycle period setting, clamped to at least 3 |
| cfg_auto | input | 1 | 1: derive window positions from the period |
| cfg_cs_start | input | PER_W | Manual select window start |
| cfg_cs_end | input | PER_W | Manual select window end (exclusive) |
| cfg_rw_start | input | PER_W | Manual write window start |
| cfg_rw_end | input | PER_W | Manual write window end (exclusive) |
| hold_sel | input | 1 | Enables the frame hold function |
| hold_frame | input | 1 | Requests a pause at the next frame start |
| pix_valid | input | 1 | A pixel word is offered |
| pix_sof | input | 1 | The offered word is the first of a frame |
| pix_data | input | DATA_W | Offered pixel word |
| pix_ready | output | 1 | The block takes the offered word this clock |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_data | output | DATA_W | Panel data bus |

## Verification
End of cycle and acceptance of the next word can fall on the same clock. The same is true of a configuration change and a running cycle, and of a frame hold and a word that would otherwise be accepted. The bench keeps pix_valid high across several words so that each handover lands on the last clock of a cycle. It rewrites the period and mode in the middle of a cycle. It raises pix_sof with both hold bits set, then with only one set. A behavioural model computes select, write, ready and data for every clock, and the bench compares these against the ports between clock edges.

// File: rtl/mcu_strobe_pkg.sv
`timescale 1ns/1ps
package mcu_strobe_pkg;
    // smallest legal bus cycle period
    localparam int unsigned MIN_PERIOD  = 3;
    // select leads the write strobe by this many clocks when room allows
    localparam int unsigned CS_LEAD     = 3;
    localparam int unsigned CS_LEAD_MIN = 2;
    // write ends above this count trim the select end by one clock
    localparam int unsigned CS_TRIM_ABOVE = 15;
    // strobe window indices
    localparam int unsigned WIN_CS  = 0;
    localparam int unsigned WIN_RW  = 1;
    localparam int unsigned NUM_WIN = 2;

    function automatic int unsigned auto_rw_start(int unsigned p);
        return ((p + 1) / 4) - 1;
    endfunction

    function automatic int unsigned auto_rw_end(int unsigned p);
        return ((3 * (p + 1)) / 4) - 1;
    endfunction

    function automatic int unsigned auto_cs_start(int unsigned rws);
        return (rws > CS_LEAD_MIN) ? (rws - CS_LEAD) : 0;
    endfunction

    function automatic int unsigned auto_cs_end(int unsigned rwe);
        return (rwe > CS_TRIM_ABOVE) ? (rwe - 1) : rwe;
    endfunction
endpackage

// File: rtl/mcu_win_calc.sv
`timescale 1ns/1ps
module mcu_win_calc
    import mcu_strobe_pkg::*;
#(
    parameter int unsigned PER_W = 5
) (
    input  logic [PER_W-1:0] cfg_period,
    input  logic             cfg_auto,
    input  logic [PER_W-1:0] cfg_cs_start,
    input  logic [PER_W-1:0] cfg_cs_end,
    input  logic [PER_W-1:0] cfg_rw_start,
    input  logic [PER_W-1:0] cfg_rw_end,
    output logic [PER_W-1:0] win_per,
    output logic [PER_W-1:0] win_cs_st,
    output logic [PER_W-1:0] win_cs_en,
    output logic [PER_W-1:0] win_rw_st,
    output logic [PER_W-1:0] win_rw_en
);
    localparam logic [PER_W-1:0] PER_FLOOR = PER_W'(MIN_PERIOD);

    int unsigned per_i;
    int unsigned rws_i;
    int unsigned rwe_i;

    always_comb begin
        win_per = (cfg_period < PER_FLOOR) ? PER_FLOOR : cfg_period;
        per_i   = int'(win_per);
        rws_i   = auto_rw_start(per_i);
        rwe_i   = auto_rw_end(per_i);
        if (cfg_auto) begin
            win_rw_st = PER_W'(rws_i);
            win_rw_en = PER_W'(rwe_i);
            win_cs_st = PER_W'(auto_cs_start(rws_i));
            win_cs_en = PER_W'(auto_cs_end(rwe_i));
        end else begin
            win_rw_st = cfg_rw_start;
            win_rw_en = cfg_rw_end;
            win_cs_st = cfg_cs_start;
            win_cs_en = cfg_cs_end;
        end
    end
endmodule

// File: rtl/mcu_cycle_ctrl.sv
`timescale 1ns/1ps
module mcu_cycle_ctrl #(
    parameter int unsigned PER_W  = 5,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PER_W-1:0]  win_per,
    input  logic [PER_W-1:0]  win_cs_st,
    input  logic [PER_W-1:0]  win_cs_en,
    input  logic [PER_W-1:0]  win_rw_st,
    input  logic [PER_W-1:0]  win_rw_en,
    input  logic              hold_sel,
    input  logic              hold_frame,
    input  logic              pix_valid,
    input  logic              pix_sof,
    input  logic [DATA_W-1:0] pix_data,
    output logic              pix_ready,
    output logic              busy,
    output logic [PER_W-1:0]  cnt,
    output logic [PER_W-1:0]  per,
    output logic [PER_W-1:0]  cs_st,
    output logic [PER_W-1:0]  cs_en,
    output logic [PER_W-1:0]  rw_st,
    output logic [PER_W-1:0]  rw_en,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        logic              busy;
        logic [PER_W-1:0]  cnt;
        logic [PER_W-1:0]  per;
        logic [PER_W-1:0]  cs_st;
        logic [PER_W-1:0]  cs_en;
        logic [PER_W-1:0]  rw_st;
        logic [PER_W-1:0]  rw_en;
        logic [DATA_W-1:0] data;
    } state_t;

    state_t st_d, st_q;
    logic   last_d;
    logic   held_d;
    logic   take_d;

    always_comb begin
        st_d      = st_q;
        last_d    = st_q.busy && (st_q.cnt == st_q.per);
        held_d    = hold_sel && hold_frame && pix_sof;
        pix_ready = (!st_q.busy || last_d) && !held_d;
        take_d    = pix_valid && pix_ready;
        if (take_d) begin
            st_d.busy  = 1'b1;
            st_d.cnt   = '0;
            st_d.per   = win_per;
            st_d.cs_st = win_cs_st;
            st_d.cs_en = win_cs_en;
            st_d.rw_st = win_rw_st;
            st_d.rw_en = win_rw_en;
            st_d.data  = pix_data;
        end else if (last_d) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt + PER_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy  = st_q.busy;
    assign cnt   = st_q.cnt;
    assign per   = st_q.per;
    assign cs_st = st_q.cs_st;
    assign cs_en = st_q.cs_en;
    assign rw_st = st_q.rw_st;
    assign rw_en = st_q.rw_en;
    assign data  = st_q.data;
endmodule

// File: rtl/mcu_strobe_dec.sv
`timescale 1ns/1ps
module mcu_strobe_dec #(
    parameter int unsigned PER_W = 5,
    parameter int unsigned NWIN  = 2
) (
    input  logic                        busy,
    input  logic [PER_W-1:0]            cnt,
    input  logic [NWIN-1:0][PER_W-1:0]  win_st,
    input  logic [NWIN-1:0][PER_W-1:0]  win_en,
    output logic [NWIN-1:0]             strobe_n
);
    for (genvar w = 0; w < NWIN; w++) begin : g_win
        assign strobe_n[w] = !(busy && (cnt >= win_st[w]) && (cnt < win_en[w]));
    end
endmodule

// File: rtl/mcu_strobe_gen.sv
`timescale 1ns/1ps
module mcu_strobe_gen
    import mcu_strobe_pkg::*;
#(
    parameter int unsigned PER_W  = 5,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PER_W-1:0]  cfg_period,
    input  logic              cfg_auto,
    input  logic [PER_W-1:0]  cfg_cs_start,
    input  logic [PER_W-1:0]  cfg_cs_end,
    input  logic [PER_W-1:0]  cfg_rw_start,
    input  logic [PER_W-1:0]  cfg_rw_end,
    input  logic              hold_sel,
    input  logic              hold_frame,
    input  logic              pix_valid,
    input  logic              pix_sof,
    input  logic [DATA_W-1:0] pix_data,
    output logic              pix_ready,
    output logic              bus_cs_n,
    output logic              bus_wr_n,
    output logic [DATA_W-1:0] bus_data
);
    logic [PER_W-1:0] win_per, win_cs_st, win_cs_en, win_rw_st, win_rw_en;
    logic             busy;
    logic [PER_W-1:0] cnt, per_q, cs_st_q, cs_en_q, rw_st_q, rw_en_q;
    logic [NUM_WIN-1:0][PER_W-1:0] st_vec, en_vec;
    logic [NUM_WIN-1:0]            strobe_n;

    mcu_win_calc #(.PER_W(PER_W)) u_calc (
        .cfg_period  (cfg_period),
        .cfg_auto    (cfg_auto),
        .cfg_cs_start(cfg_cs_start),
        .cfg_cs_end  (cfg_cs_end),
        .cfg_rw_start(cfg_rw_start),
        .cfg_rw_end  (cfg_rw_end),
        .win_per     (win_per),
        .win_cs_st   (win_cs_st),
        .win_cs_en   (win_cs_en),
        .win_rw_st   (win_rw_st),
        .win_rw_en   (win_rw_en)
    );

    mcu_cycle_ctrl #(.PER_W(PER_W), .DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_per   (win_per),
        .win_cs_st (win_cs_st),
        .win_cs_en (win_cs_en),
        .win_rw_st (win_rw_st),
        .win_rw_en (win_rw_en),
        .hold_sel  (hold_sel),
        .hold_frame(hold_frame),
        .pix_valid (pix_valid),
        .pix_sof   (pix_sof),
        .pix_data  (pix_data),
        .pix_ready (pix_ready),
        .busy      (busy),
        .cnt       (cnt),
        .per       (per_q),
        .cs_st     (cs_st_q),
        .cs_en     (cs_en_q),
        .rw_st     (rw_st_q),
        .rw_en     (rw_en_q),
        .data      (bus_data)
    );

    always_comb begin
        st_vec         = '0;
        en_vec         = '0;
        st_vec[WIN_CS] = cs_st_q;
        en_vec[WIN_CS] = cs_en_q;
        st_vec[WIN_RW] = rw_st_q;
        en_vec[WIN_RW] = rw_en_q;
    end

    mcu_strobe_dec #(.PER_W(PER_W), .NWIN(NUM_WIN)) u_dec (
        .busy    (busy),
        .cnt     (cnt),
        .win_st  (st_vec),
        .win_en  (en_vec),
        .strobe_n(strobe_n)
    );

    assign bus_cs_n = strobe_n[WIN_CS];
    assign bus_wr_n = strobe_n[WIN_RW];
endmodule

// File: rtl/mcu_strobe_chk.sv
`timescale 1ns/1ps
module mcu_strobe_chk #(
    parameter int unsigned PER_W  = 5,
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic [PER_W-1:0]  cnt,
    input logic [PER_W-1:0]  per,
    input logic              hold_sel,
    input logic              hold_frame,
    input logic              pix_sof,
    input logic              pix_ready,
    input logic              bus_cs_n,
    input logic              bus_wr_n,
    input logic [DATA_W-1:0] bus_data
);
    assert_cnt_in_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt <= per));

    assert_period_floor_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (per >= PER_W'(3)));

    assert_ready_only_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (cnt != per)) |-> !pix_ready);

    assert_count_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (cnt != per)) |=> (busy && (cnt == $past(cnt) + PER_W'(1))));

    assert_data_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (cnt != '0)) |-> $stable(bus_data));

    assert_hold_blocks_sof_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_sel && hold_frame && pix_sof) |-> !pix_ready);

    assert_idle_strobes_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_cs_n && bus_wr_n));
endmodule

bind mcu_strobe_gen mcu_strobe_chk #(.PER_W(PER_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .cnt       (cnt),
    .per       (per_q),
    .hold_sel  (hold_sel),
    .hold_frame(hold_frame),
    .pix_sof   (pix_sof),
    .pix_ready (pix_ready),
    .bus_cs_n  (bus_cs_n),
    .bus_wr_n  (bus_wr_n),
    .bus_data  (bus_data)
);

// File: tb/sim_mcu_strobe_gen.sv
`timescale 1ns/1ps
module sim_mcu_strobe_gen;
    localparam int PW = 5;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [PW-1:0] cfg_period = 5'd7;
    logic          cfg_auto = 1'b1;
    logic [PW-1:0] cfg_cs_start = '0, cfg_cs_end = '0, cfg_rw_start = '0, cfg_rw_end = '0;
    logic          hold_sel = 1'b0, hold_frame = 1'b0;
    logic          tb_valid = 1'b0, tb_sof = 1'b0;
    logic [DW-1:0] tb_data = 16'h1234;
    logic          pix_ready, bus_cs_n, bus_wr_n;
    logic [DW-1:0] bus_data;

    mcu_strobe_gen #(.PER_W(PW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_period(cfg_period), .cfg_auto(cfg_auto),
        .cfg_cs_start(cfg_cs_start), .cfg_cs_end(cfg_cs_end),
        .cfg_rw_start(cfg_rw_start), .cfg_rw_end(cfg_rw_end),
        .hold_sel(hold_sel), .hold_frame(hold_frame),
        .pix_valid(tb_valid), .pix_sof(tb_sof), .pix_data(tb_data),
        .pix_ready(pix_ready), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n),
        .bus_data(bus_data)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int words_left = 0;
    string phase = "R9 reset";

    // behavioural reference state
    int m_busy = 0, m_cnt = 0, m_per = 3, m_auto = 1;
    int m_cs_st = 0, m_cs_en = 0, m_rw_st = 0, m_rw_en = 0;
    int m_data = 0;

    function automatic int held_now();
        return (hold_sel && hold_frame && tb_sof) ? 1 : 0;
    endfunction

    function automatic int exp_ready();
        return ((m_busy == 0 || m_cnt == m_per) && held_now() == 0) ? 1 : 0;
    endfunction

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s (%s) t=%0t actual=%0d expected=%0d", req, phase, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        int ecs, ewr;
        ecs = (m_busy != 0 && m_cnt >= m_cs_st && m_cnt < m_cs_en) ? 0 : 1;
        ewr = (m_busy != 0 && m_cnt >= m_rw_st && m_cnt < m_rw_en) ? 0 : 1;
        check(m_auto != 0 ? "R3" : "R4", int'(bus_cs_n), ecs);
        check(m_auto != 0 ? "R2" : "R4", int'(bus_wr_n), ewr);
        check(held_now() != 0 ? "R8" : "R1", int'(pix_ready), exp_ready());
        if (m_busy != 0) check("R5", int'(bus_data), m_data);
    endtask

    task automatic tick();
        int acc;
        @(posedge clk);
        acc = (tb_valid && exp_ready() != 0) ? 1 : 0;
        if (acc != 0) begin
            m_busy = 1;
            m_cnt  = 0;
            m_per  = (int'(cfg_period) < 3) ? 3 : int'(cfg_period);
            m_auto = int'(cfg_auto);
            if (cfg_auto) begin
                m_rw_st = (m_per + 1) / 4 - 1;
                m_rw_en = (3 * (m_per + 1)) / 4 - 1;
                m_cs_st = (m_rw_st > 2) ? m_rw_st - 3 : 0;
                m_cs_en = (m_rw_en > 15) ? m_rw_en - 1 : m_rw_en;
            end else begin
                m_cs_st = int'(cfg_cs_start);
                m_cs_en = int'(cfg_cs_end);
                m_rw_st = int'(cfg_rw_start);
                m_rw_en = int'(cfg_rw_end);
            end
            m_data = int'(tb_data);
        end else if (m_busy != 0 && m_cnt == m_per) begin
            m_busy = 0;
            m_cnt  = 0;
        end else if (m_busy != 0) begin
            m_cnt++;
        end
        @(negedge clk);
        if (acc != 0) begin
            tb_data = tb_data + 16'h0f11;
            tb_sof  = 1'b0;
            if (words_left > 0) words_left--;
            if (words_left == 0) tb_valid = 1'b0;
        end
        #1 compare_all();
    endtask

    task automatic send(int n, logic sof);
        words_left = n;
        tb_sof     = sof;
        tb_valid   = 1'b1;
        for (int g = 0; g < 2000 && words_left > 0; g++) tick();
        tick();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9: quiet bus after reset
        check("R9", int'(bus_cs_n), 1);
        check("R9", int'(bus_wr_n), 1);
        check("R9", int'(pix_ready), 1);
        check("R9", int'(bus_data), 0);
        idle(3);

        phase = "R2 R3 R7 auto period 7 back-to-back";
        cfg_auto = 1'b1; cfg_period = 5'd7;
        send(4, 1'b0);
        idle(3);

        phase = "R3 auto period 31 end trim";
        cfg_period = 5'd31;
        send(2, 1'b0);
        idle(2);

        phase = "R1 period below floor";
        cfg_period = 5'd1;
        send(3, 1'b0);
        cfg_period = 5'd0;
        send(2, 1'b0);
        idle(2);

        phase = "R4 manual windows";
        cfg_auto = 1'b0; cfg_period = 5'd12;
        cfg_cs_start = 5'd2; cfg_cs_end = 5'd9;
        cfg_rw_start = 5'd4; cfg_rw_end = 5'd7;
        send(3, 1'b0);
        cfg_cs_start = 5'd0; cfg_cs_end = 5'd20;
        cfg_rw_start = 5'd1; cfg_rw_end = 5'd2;
        send(2, 1'b0);
        idle(2);

        phase = "R6 mid-cycle config change";
        cfg_auto = 1'b1; cfg_period = 5'd5;
        words_left = 2; tb_sof = 1'b0; tb_valid = 1'b1;
        idle(2);
        cfg_period = 5'd20; cfg_auto = 1'b0;
        cfg_cs_start = 5'd1; cfg_cs_end = 5'd15;
        cfg_rw_start = 5'd3; cfg_rw_end = 5'd10;
        for (int g = 0; g < 200 && words_left > 0; g++) tick();
        idle(25);

        phase = "R8 frame hold on start word";
        cfg_auto = 1'b1; cfg_period = 5'd4;
        hold_sel = 1'b1; hold_frame = 1'b1;
        words_left = 1; tb_sof = 1'b1; tb_valid = 1'b1;
        idle(8);
        hold_frame = 1'b0;
        for (int g = 0; g < 200 && words_left > 0; g++) tick();
        idle(6);

        phase = "R8 hold ignores non-start words";
        hold_frame = 1'b1;
        send(2, 1'b0);
        idle(2);

        phase = "R8 single hold bit only";
        hold_sel = 1'b0; hold_frame = 1'b1;
        send(1, 1'b1);
        hold_sel = 1'b1; hold_frame = 1'b0;
        send(1, 1'b1);
        hold_sel = 1'b0;
        idle(3);

        phase = "R7 R5 gapped stream";
        cfg_period = 5'd9;
        send(1, 1'b0);
        idle(1);
        send(3, 1'b1);
        idle(4);

        summary();
        $finish;
    end
endmodule